// File: doc/BRIEF.md
# Six-Pin GPIO Controller with Change Interrupts

This block manages six general-purpose pins through a small byte-wide register bus. Software picks a direction for each pin and moves output levels only through two write-one registers, one that raises bits and one that lowers them. A read-only register returns the synchronized level seen on every pad. Input pins go through a synchronizer and an edge detector. Each detected change leaves a sticky pending flag. The interrupt line is raised while any unmasked input pin has a pending flag, and reading the pending register clears the flags that the read returned.

The highest pin can be handed to a transmit-enable function for an external line driver. A mode bit claims the pin, which then becomes an output whatever its direction bit says. A polarity bit chooses whether the pin goes high or low while the transmitter-busy input is asserted. There is no streaming data path here, so every pin is plain control or status. The bus has no back-pressure: a write takes effect at the clock edge where it is presented, and read data is valid in the same cycle as the read strobe.

Register map (3-bit address): 0 mode (bit 0 claims pin 5 for transmit enable, bit 1 is the polarity), 1 direction, 2 interrupt mask, 3 set, 4 clear, 5 pin status, 6 pending. Address 7 reads as zero.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: After reset, every pin is an input (pin_oe = 0), every output latch bit is 0, the mask register reads 0x3F, the mode register reads 0, no flag is pending and irq is 0.
- R2: For a pin that the mode register does not claim, pin_oe follows its direction bit: 1 makes the pin an output, 0 makes it an input.
- R3: A write to address 3 sets every output latch bit whose data bit is 1 and leaves the bits written as 0 unchanged. Addresses 3 and 4 both read back the output latch.
- R4: A write to address 4 clears every output latch bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R5: Address 5 returns each pad level delayed by two clock edges through the synchronizer. Writes to address 5 change nothing.
- R6: A change of a synchronized level on a pin that is an input sets that pin's pending flag, and the flag stays set until it is read. A change on an output pin sets no flag.
- R7: irq is 1 exactly when some pin is an input, has its pending flag set, and has its mask bit at 0. A mask bit of 1 keeps that pin from raising irq.
- R8: A read of address 6 returns the pending flags and clears the returned flags at that edge. A change detected in the same cycle stays pending.
- R9: With mode bit 0 set, pin 5 is driven (pin_oe[5] = 1) whatever its direction bit says. While tx_busy is 1, pin 5 takes the level of polarity bit 1, and while tx_busy is 0 it takes the opposite level.
- R10: Data bits 7 and 6 are ignored on every write and read as 0. Mode bits 7..2 are ignored, and address 7 reads as 0.
- R11: While pin 5 is claimed for transmit enable, changes on its pad set no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; clears pending flags when the address is 6 |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |
| pin_in | input | 6 | Asynchronous pad levels |
| pin_out | output | 6 | Pad output levels |
| pin_oe | output | 6 | Pad output enables |
| tx_busy | input | 1 | Transmitter active, drives pin 5 in transmit-enable mode |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can act in the same cycle: a read that clears the pending flags and the detection of a new edge on an input. The bench changes a pad and then times a pending read so that it lands on the edge where the synchronizer reports that change. It expects the read to return the old flags and the next read to return the new flag. A behavioural reference model, built on a history queue of pad samples, predicts pin_out, pin_oe and irq, and the bench compares them with the design after every clock. Direct register reads are compared with the model and with fixed values.

// File: rtl/gpio_chg_pkg.sv
`timescale 1ns/1ps
package gpio_chg_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_MODE = 3'd0,
    A_DIR  = 3'd1,
    A_MASK = 3'd2,
    A_SET  = 3'd3,
    A_CLR  = 3'd4,
    A_STAT = 3'd5,
    A_PEND = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;

  localparam int unsigned MODE_ON_BIT  = 0;
  localparam int unsigned MODE_POL_BIT = 1;
endpackage

// File: rtl/gpio_chg_sync.sv
`timescale 1ns/1ps
module gpio_chg_sync #(
  parameter int NPINS  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] chg_o
);
  logic [NPINS-1:0] stg [STAGES];
  logic [NPINS-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];
  end

  assign lvl_o = stg[STAGES-1];
  assign chg_o = stg[STAGES-1] ^ prev_q;
endmodule

// File: rtl/gpio_chg_regs.sv
`timescale 1ns/1ps
module gpio_chg_regs
  import gpio_chg_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [NPINS-1:0]  stat_i,
  input  logic [NPINS-1:0]  pend_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  out_o,
  output logic              txen_on_o,
  output logic              txen_pol_o,
  output logic              pend_rd_o
);
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] dir_q, mask_q, out_q;
  logic             on_q, pol_q;
  logic [DW-1:0]    rword;

  assign wbits = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '1;
      out_q  <= '0;
      on_q   <= 1'b0;
      pol_q  <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: begin
          on_q  <= bus_wdata[MODE_ON_BIT];
          pol_q <= bus_wdata[MODE_POL_BIT];
        end
        A_DIR:  dir_q  <= wbits;
        A_MASK: mask_q <= wbits;
        A_SET:  out_q  <= out_q | wbits;
        A_CLR:  out_q  <= out_q & ~wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rword = '0;
    case (bus_addr)
      A_MODE: begin
        rword[MODE_ON_BIT]  = on_q;
        rword[MODE_POL_BIT] = pol_q;
      end
      A_DIR:  rword[NPINS-1:0] = dir_q;
      A_MASK: rword[NPINS-1:0] = mask_q;
      A_SET:  rword[NPINS-1:0] = out_q;
      A_CLR:  rword[NPINS-1:0] = out_q;
      A_STAT: rword[NPINS-1:0] = stat_i;
      A_PEND: rword[NPINS-1:0] = pend_i;
      default: rword = '0;
    endcase
  end

  assign rdata_o    = rword;
  assign dir_o      = dir_q;
  assign mask_o     = mask_q;
  assign out_o      = out_q;
  assign txen_on_o  = on_q;
  assign txen_pol_o = pol_q;
  assign pend_rd_o  = bus_rd && (bus_addr == A_PEND);
endmodule

// File: rtl/gpio_chg_pend.sv
`timescale 1ns/1ps
module gpio_chg_pend #(
  parameter int NPINS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] chg_i,
  input  logic [NPINS-1:0] is_in_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic             rd_clr_i,
  output logic [NPINS-1:0] pend_o,
  output logic             irq_o
);
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] fresh;

  assign fresh = chg_i & is_in_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= '0;
    else if (rd_clr_i) pend_q <= fresh;
    else               pend_q <= pend_q | fresh;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ~mask_i & is_in_i);
endmodule

// File: rtl/gpio_chg_ctrl.sv
`timescale 1ns/1ps
module gpio_chg_ctrl
  import gpio_chg_pkg::*;
#(
  parameter int NPINS    = 6,
  parameter int DW       = 8,
  parameter int STAGES   = 2,
  parameter int TXEN_PIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic              tx_busy,
  output logic              irq
);
  logic [NPINS-1:0] lvl_w, chg_w, dir_w, mask_w, out_w, pend_w, claim_w, is_in_w;
  logic             txen_on_w, txen_pol_w, pend_rd_w;

  gpio_chg_sync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .lvl_o(lvl_w), .chg_o(chg_w)
  );

  gpio_chg_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_i(lvl_w), .pend_i(pend_w),
    .rdata_o(bus_rdata), .dir_o(dir_w), .mask_o(mask_w), .out_o(out_w),
    .txen_on_o(txen_on_w), .txen_pol_o(txen_pol_w), .pend_rd_o(pend_rd_w)
  );

  gpio_chg_pend #(.NPINS(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .chg_i(chg_w), .is_in_i(is_in_w), .mask_i(mask_w),
    .rd_clr_i(pend_rd_w), .pend_o(pend_w), .irq_o(irq)
  );

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      if (i == TXEN_PIN) begin : g_txen
        assign claim_w[i] = txen_on_w;
        assign pin_oe[i]  = dir_w[i] | txen_on_w;
        assign pin_out[i] = txen_on_w ? (tx_busy ? txen_pol_w : ~txen_pol_w) : out_w[i];
      end else begin : g_plain
        assign claim_w[i] = 1'b0;
        assign pin_oe[i]  = dir_w[i];
        assign pin_out[i] = out_w[i];
      end
      assign is_in_w[i] = ~dir_w[i] & ~claim_w[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_chg_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_chg_ctrl_chk
  import gpio_chg_pkg::*;
#(
  parameter int NPINS    = 6,
  parameter int DW       = 8,
  parameter int TXEN_PIN = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              tx_busy,
  input logic              irq,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  pend_q,
  input logic              txen_on,
  input logic              txen_pol
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && !irq && out_q == '0));

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=>
      ((out_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((out_q & $past(bus_wdata[NPINS-1:0])) == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == A_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_q & ~mask_q) != '0));

  p_txen_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txen_on |-> pin_oe[TXEN_PIN]);

  p_txen_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txen_on && tx_busy && !txen_pol) |-> !pin_out[TXEN_PIN]);

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_rdata[DW-1:NPINS] == '0));
endmodule

bind gpio_chg_ctrl gpio_chg_ctrl_chk #(.NPINS(NPINS), .DW(DW), .TXEN_PIN(TXEN_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .tx_busy(tx_busy), .irq(irq), .out_q(out_w), .mask_q(mask_w), .pend_q(pend_w),
  .txen_on(txen_on_w), .txen_pol(txen_pol_w)
);

// File: tb/gpio_chg_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_chg_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pin_in = '0;
  logic [5:0] pin_out, pin_oe;
  logic       tx_busy = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_chg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .tx_busy(tx_busy), .irq(irq)
  );

  // Reference model state
  logic [5:0] m_dir, m_mask, m_out, m_pend;
  logic       m_on, m_pol;
  logic [5:0] hist[$];

  function automatic logic [5:0] m_isin();
    return ~m_dir & ~(m_on ? 6'h20 : 6'h00);
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {6'b0, m_pol, m_on};
      3'd1: return {2'b0, m_dir};
      3'd2: return {2'b0, m_mask};
      3'd3, 3'd4: return {2'b0, m_out};
      3'd5: return {2'b0, hist[1]};
      3'd6: return {2'b0, m_pend};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = '0; m_mask = '1; m_out = '0; m_pend = '0; m_on = 0; m_pol = 0;
      hist = '{6'h0, 6'h0, 6'h0};
    end else begin
      logic [5:0] newp;
      newp = (hist[1] ^ hist[2]) & m_isin();
      if (bus_rd && bus_addr == 3'd6) m_pend = newp;
      else                            m_pend = m_pend | newp;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin m_on = bus_wdata[0]; m_pol = bus_wdata[1]; end
          3'd1: m_dir  = bus_wdata[5:0];
          3'd2: m_mask = bus_wdata[5:0];
          3'd3: m_out  = m_out | bus_wdata[5:0];
          3'd4: m_out  = m_out & ~bus_wdata[5:0];
          default: ;
        endcase
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
    #1;
    if (rst_n) begin
      logic [5:0] eo;
      eo = m_out;
      if (m_on) eo[5] = tx_busy ? m_pol : ~m_pol;
      check("R2/R9 per-cycle pin_oe", {2'b0, pin_oe}, {2'b0, m_dir | (m_on ? 6'h20 : 6'h00)});
      check("R3/R4/R9 per-cycle pin_out", {2'b0, pin_out}, {2'b0, eo});
      check("R7 per-cycle irq", {7'b0, irq}, {7'b0, |(m_pend & ~m_mask & m_isin())});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input int lit);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1;
    check(tag, bus_rdata, m_read(a));
    if (lit >= 0) check({tag, " literal"}, bus_rdata, 8'(lit));
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd(3'd0, "R1 mode", 0);
    rd(3'd1, "R1 dir", 0);
    rd(3'd2, "R1 mask", 8'h3F);
    rd(3'd3, "R1 out", 0);
    rd(3'd6, "R1 pend", 0);
    check("R1 irq", {7'b0, irq}, 8'h00);
    // R2 direction
    wr(3'd1, 8'h0F);
    #1 check("R2 oe", {2'b0, pin_oe}, 8'h0F);
    // R3 set, R10 reserved bits
    wr(3'd3, 8'h05);
    rd(3'd3, "R3 set readback", 8'h05);
    wr(3'd3, 8'hC2);
    rd(3'd3, "R10 reserved set ignored", 8'h07);
    // R4 clear
    wr(3'd4, 8'h03);
    rd(3'd4, "R4 clear readback", 8'h04);
    wr(3'd4, 8'h00);
    rd(3'd3, "R4 zero write no effect", 8'h04);
    // R5 status
    @(negedge clk) pin_in = 6'b110000;
    idle(3);
    rd(3'd5, "R5 status", 8'h30);
    wr(3'd5, 8'hFF);
    rd(3'd5, "R5 status write ignored", 8'h30);
    rd(3'd1, "R5 dir untouched", 8'h0F);
    // R6 pending on inputs, R7 masked
    check("R7 masked irq", {7'b0, irq}, 8'h00);
    rd(3'd6, "R6 pend inputs", 8'h30);
    rd(3'd6, "R8 pend cleared", 8'h00);
    @(negedge clk) pin_in[0] = 1'b1;
    idle(4);
    rd(3'd6, "R6 output pin no pend", 8'h00);
    // R7 unmask pin 4
    wr(3'd2, 8'h2F);
    @(negedge clk) pin_in[4] = 1'b0;
    idle(4);
    #1 check("R7 irq unmasked", {7'b0, irq}, 8'h01);
    rd(3'd6, "R7 pend pin4", 8'h10);
    #1 check("R7 irq after clear", {7'b0, irq}, 8'h00);
    @(negedge clk) pin_in[5] = 1'b0;
    idle(4);
    #1 check("R7 masked pin5 no irq", {7'b0, irq}, 8'h00);
    // R8 read/edge collision
    @(negedge clk) pin_in[4] = 1'b1;
    @(negedge clk);
    rd(3'd6, "R8 collision read", 8'h20);
    rd(3'd6, "R8 edge survives clear", 8'h10);
    // R9 transmit enable
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);
    #1 check("R9 oe claimed", {7'b0, pin_oe[5]}, 8'h01);
    @(negedge clk) tx_busy = 1;
    #1 check("R9 pol0 busy low", {7'b0, pin_out[5]}, 8'h00);
    @(negedge clk) tx_busy = 0;
    #1 check("R9 pol0 idle high", {7'b0, pin_out[5]}, 8'h01);
    wr(3'd0, 8'h03);
    @(negedge clk) tx_busy = 1;
    #1 check("R9 pol1 busy high", {7'b0, pin_out[5]}, 8'h01);
    // R11 claimed pin changes ignored
    @(negedge clk) pin_in[5] = 1'b1;
    idle(4);
    rd(3'd6, "R11 claimed pin no pend", 8'h00);
    #1 check("R11 irq quiet", {7'b0, irq}, 8'h00);
    // R10 mode reserved bits, unmapped address
    wr(3'd0, 8'hFC);
    rd(3'd0, "R10 mode reserved", 8'h00);
    rd(3'd7, "R10 unmapped", 8'h00);
    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule